// File: doc/BRIEF.md
# Live-Insertion Bus Connect Sequencer

This block is the control logic for a two-segment I2C/SMBus buffer on a plug-in card. It decides when the card-side bus segment may be joined to the live backplane segment. It reads digital supply-health flags for both sides, plus the levels of the four bus pins: data and clock on the backplane side, and data and clock on the card side. From these it drives three enables: one that joins the segments, one for the pin precharge, and one for the rise-time accelerators.

After power comes up, the sequencer waits out a fixed settling period with precharge on. It then watches the bus and joins the segments only at a safe point. A safe point is either every pin staying high for a programmable idle window, or a STOP condition on the backplane while every pin is high. Once joined, the segments stay joined until a supply fails. A static accelerator-enable input decides whether the accelerators run after the join, or whether precharge is kept on instead. All timers advance on a shared tick strobe, so their lengths are counts of ticks.

Top module: `hs_bus_connect`

## Requirements
- R1: After reset the state is lockout. Lockout holds `connect_o`, `precharge_o` and `accel_o` low. Lockout is left only in a cycle where both `bp_pwr_ok_i` and `card_pwr_ok_i` are high, in either arrival order.
- R2: Either `bp_pwr_low_i` or `card_pwr_low_i` high at a clock edge sends the block to lockout on that edge, from any state.
- R3: An ok flag that falls while both low flags stay low does not change the current state (hysteresis).
- R4: On leaving lockout, the block enters an initialization state with `precharge_o` high. Initialization lasts exactly INIT_TICKS ticked cycles. After it, the block enters the watch state, where `precharge_o` stays high and `connect_o` stays low.
- R5: In watch, the segments are joined once all four synchronized pins have been high during IDLE_TICKS consecutive ticked cycles. Any pin sampled low restarts that count.
- R6: In watch, the segments are also joined when all four synchronized pins are high and the synchronized backplane data pin rises while the backplane clock pin is high in both the current and previous samples. The same edge in any other state has no effect.
- R7: Each pin passes through a SYNC_STAGES-flop synchronizer (default 2) before any detection.
- R8: While joined, `accel_o` equals `acc_en_i` and `precharge_o` equals the inverse of `acc_en_i`.
- R9: Once joined, `connect_o` stays high until a low-supply flag forces lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer advance strobe |
| bp_pwr_ok_i | input | 1 | Backplane supply above the upper threshold |
| card_pwr_ok_i | input | 1 | Card supply above the upper threshold |
| bp_pwr_low_i | input | 1 | Backplane supply below the lower threshold |
| card_pwr_low_i | input | 1 | Card supply below the lower threshold |
| bp_sda_i | input | 1 | Backplane data pin level |
| bp_scl_i | input | 1 | Backplane clock pin level |
| card_sda_i | input | 1 | Card data pin level |
| card_scl_i | input | 1 | Card clock pin level |
| acc_en_i | input | 1 | Accelerator enable request |
| connect_o | output | 1 | Join backplane and card segments |
| precharge_o | output | 1 | Pin precharge enable |
| accel_o | output | 1 | Rise-time accelerator enable |

## Verification
The bench targets several corner cases. The first is a single-cycle low pulse on one card pin midway through the idle window: a design that failed to restart its count would join early, in the middle of a transfer. The second is a backplane STOP edge during initialization: joining on it would mean the detector was armed too soon. The third is a STOP with the data line low for a long time beforehand, to confirm that the join comes from the edge and not from the idle timer. The last is an ok flag dropping without its low flag: a design without hysteresis would disconnect a working card there. Supply loss during initialization and during the joined state is also applied. Every output is compared each cycle against a behavioural model, which exposes any latency error in the synchronizer or the timers.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [1:0] {
    ST_LOCK  = 2'd0,
    ST_INIT  = 2'd1,
    ST_WATCH = 2'd2,
    ST_CONN  = 2'd3
  } hsc_state_e;

  localparam int unsigned NUM_PINS = 4;
  localparam int unsigned PIN_BP_SCL = 0;
  localparam int unsigned PIN_BP_SDA = 1;
endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hsc_tick_timer.sv
module hsc_tick_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // done fires on the edge that completes the LIMIT-th tick
  assign done_o = !clr_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (tick_i && !done_o)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hsc_bus_watch.sv
module hsc_bus_watch
  import hsc_pkg::*;
#(
  parameter int unsigned IDLE_TICKS = 28
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arm_i,
  input  logic                tick_i,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic                join_o
);
  logic sda_q, scl_q;
  logic all_high, stop_hit, idle_done;

  assign all_high = &pins_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b0;
      scl_q <= 1'b0;
    end else begin
      sda_q <= pins_i[PIN_BP_SDA];
      scl_q <= pins_i[PIN_BP_SCL];
    end
  end

  // STOP: data rises with clock high on both samples
  assign stop_hit = arm_i && all_high && !sda_q && scl_q;

  hsc_tick_timer #(.LIMIT(IDLE_TICKS)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!arm_i || !all_high),
    .tick_i (tick_i),
    .done_o (idle_done)
  );

  assign join_o = stop_hit || idle_done;

  // R5
  idle_join_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_done |-> (&pins_i));
  // R6
  join_only_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    join_o |-> arm_i);
endmodule

// File: rtl/hs_bus_connect.sv
module hs_bus_connect
  import hsc_pkg::*;
#(
  parameter int unsigned INIT_TICKS  = 36,
  parameter int unsigned IDLE_TICKS  = 28,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic bp_pwr_ok_i,
  input  logic card_pwr_ok_i,
  input  logic bp_pwr_low_i,
  input  logic card_pwr_low_i,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  input  logic card_sda_i,
  input  logic card_scl_i,
  input  logic acc_en_i,
  output logic connect_o,
  output logic precharge_o,
  output logic accel_o
);
  hsc_state_e st_q, st_d;
  logic [NUM_PINS-1:0] pin_raw, pin_s;
  logic drop, init_done, join_w;

  assign pin_raw = {card_sda_i, card_scl_i, bp_sda_i, bp_scl_i};
  assign drop    = bp_pwr_low_i || card_pwr_low_i;

  hsc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_raw),
    .q_o    (pin_s)
  );

  hsc_tick_timer #(.LIMIT(INIT_TICKS)) u_init (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q != ST_INIT),
    .tick_i (tick_i),
    .done_o (init_done)
  );

  hsc_bus_watch #(.IDLE_TICKS(IDLE_TICKS)) u_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (st_q == ST_WATCH),
    .tick_i (tick_i),
    .pins_i (pin_s),
    .join_o (join_w)
  );

  always_comb begin
    st_d = st_q;
    if (drop) st_d = ST_LOCK;
    else begin
      unique case (st_q)
        ST_LOCK:  if (bp_pwr_ok_i && card_pwr_ok_i) st_d = ST_INIT;
        ST_INIT:  if (init_done) st_d = ST_WATCH;
        ST_WATCH: if (join_w)    st_d = ST_CONN;
        ST_CONN:  st_d = ST_CONN;
        default:  st_d = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_LOCK;
    else         st_q <= st_d;
  end

  assign connect_o   = (st_q == ST_CONN);
  assign accel_o     = (st_q == ST_CONN) && acc_en_i;
  assign precharge_o = (st_q == ST_INIT) || (st_q == ST_WATCH) ||
                       ((st_q == ST_CONN) && !acc_en_i);

  // R1
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOCK && !(bp_pwr_ok_i && card_pwr_ok_i)) |=> (st_q == ST_LOCK));
  // R2
  drop_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> (!connect_o && !accel_o && !precharge_o));
  // R4
  init_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_INIT && !init_done && !drop) |=> (st_q == ST_INIT));
  // R9
  conn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (connect_o && !drop) |=> connect_o);
endmodule

// File: tb/sim_hs_bus_connect.sv
module sim_hs_bus_connect;
  localparam int INIT_T = 12;
  localparam int IDLE_T = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic bp_ok = 0, cd_ok = 0, bp_low = 0, cd_low = 0;
  logic bp_sda = 0, bp_scl = 0, cd_sda = 0, cd_scl = 0;
  logic acc = 1'b1;
  logic connect, precharge, accel;

  int vectors = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  hs_bus_connect #(.INIT_TICKS(INIT_T), .IDLE_TICKS(IDLE_T)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .bp_pwr_ok_i(bp_ok), .card_pwr_ok_i(cd_ok),
    .bp_pwr_low_i(bp_low), .card_pwr_low_i(cd_low),
    .bp_sda_i(bp_sda), .bp_scl_i(bp_scl),
    .card_sda_i(cd_sda), .card_scl_i(cd_scl),
    .acc_en_i(acc),
    .connect_o(connect), .precharge_o(precharge), .accel_o(accel)
  );

  // behavioural reference: 0 lockout, 1 init, 2 watch, 3 joined
  int m_st = 0;
  int m_init = 0;
  int m_idle = 0;
  logic [3:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_init = 0; m_idle = 0;
      hist = {4'h0, 4'h0, 4'h0, 4'h0};
    end else begin
      logic [3:0] now_s, old_s;
      bit hi, stop;
      hist.push_front({cd_sda, cd_scl, bp_sda, bp_scl});
      void'(hist.pop_back());
      now_s = hist[2];
      old_s = hist[3];
      if (bp_low || cd_low) m_st = 0;
      else if (m_st == 0) begin
        if (bp_ok && cd_ok) begin m_st = 1; m_init = 0; end
      end else if (m_st == 1) begin
        if (tick) begin
          if (m_init == INIT_T - 1) begin m_st = 2; m_idle = 0; end
          else m_init++;
        end
      end else if (m_st == 2) begin
        hi = (now_s == 4'hF);
        stop = hi && !old_s[1] && old_s[0];
        if (stop) m_st = 3;
        else if (!hi) m_idle = 0;
        else if (tick) begin
          if (m_idle == IDLE_T - 1) m_st = 3;
          else m_idle++;
        end
      end
    end
  end

  task automatic compare();
    logic e_c, e_p, e_a;
    e_c = (m_st == 3);
    e_a = (m_st == 3) && acc;
    e_p = (m_st == 1) || (m_st == 2) || ((m_st == 3) && !acc);
    vectors++;
    if (connect !== e_c) begin
      errors++;
      $display("FAIL %s connect_o got %b exp %b cycle %0d", cur_req, connect, e_c, cyc);
    end
    if (precharge !== e_p) begin
      errors++;
      $display("FAIL %s precharge_o got %b exp %b cycle %0d", cur_req, precharge, e_p, cyc);
    end
    if (accel !== e_a) begin
      errors++;
      $display("FAIL %s accel_o got %b exp %b cycle %0d", cur_req, accel, e_a, cyc);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      compare();
      tick <= (cyc % 2 == 0);
    end
  endtask

  task automatic set_pins(input logic v);
    bp_sda = v; bp_scl = v; cd_sda = v; cd_scl = v;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired, cycle %0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    step(3);
    rst_n = 1'b1;
    step(4);
    bp_ok = 1;                       // R1: one supply only
    step(10);
    cur_req = "R4";
    cd_ok = 1;
    step(40);                        // init then watch with pins low
    cur_req = "R5";
    set_pins(1);
    step(12);
    cd_scl = 0;                      // R5: one-cycle glitch restarts idle
    step(1);
    cd_scl = 1;
    step(14);
    step(20);                        // idle join
    cur_req = "R8";
    acc = 0; step(5);
    acc = 1; step(5);
    cur_req = "R3";
    bp_ok = 0; step(10);             // hysteresis, stays joined
    cur_req = "R9";
    step(5);
    cur_req = "R2";
    bp_low = 1; step(3);
    bp_low = 0; step(5);             // ok still low: stays locked
    bp_ok = 1; step(6);
    cd_low = 1; step(2);             // drop during init
    cd_low = 0; step(4);
    cur_req = "R6";
    bp_sda = 0; step(3);             // STOP edge during init: ignored
    bp_sda = 1; step(4);
    bp_sda = 0;
    step(40);                        // into watch, data low blocks idle
    cur_req = "R7";
    bp_sda = 1; step(6);             // STOP join
    cur_req = "R2";
    cd_low = 1; step(2);
    cd_low = 0;
    cur_req = "R6";
    acc = 0;
    bp_scl = 0; step(30);            // clock low: no stop, no idle
    bp_sda = 0; step(3);
    bp_scl = 1; step(3);
    bp_sda = 1; step(6);             // STOP with acc off
    step(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule